// File: doc/BRIEF.md
# Line/Ring Packet Forwarding Node

This block is the packet switch inside one node of a line or ring network. Packets come in from the upstream link as a byte stream with an end-of-packet flag. Every packet opens with a four-byte header: byte 0 format code, byte 1 source ID, byte 2 destination ID, byte 3 hop count. Payload bytes follow. The switch holds the first three header bytes in registers. When the hop byte arrives it decides, in that same cycle, where the packet goes. The packet can be consumed and handed to the local host port, forwarded to the downstream link, sent to both, or discarded.

Forwarding is cut-through. The held header bytes leave downstream as soon as the decision is made, and payload bytes then follow straight from the upstream port. The switch does not wait for the packet to end. The hop count is incremented on the way through.

Packets from the local host are stamped with this node's ID as their source and a zero hop count. They share the downstream link with forwarded traffic. Whole packets alternate first come, first served, and packets never interleave.

The node ID, topology mode, end-of-line flag and hop limit are static configuration inputs.

Top module: `ring_node_switch`

## Requirements
- R1: Routing is decided on the fourth byte of a packet. A packet that ends before its fourth byte is discarded entirely and produces no output on either port. A header-only packet of 4 bytes is routed like any other packet.
- R2: A packet whose destination byte equals `node_id` or equals 254 is delivered byte-exact on the host output and produces nothing downstream.
- R3: A packet with destination 255 is delivered unchanged to the host and also forwarded. There is one exception: with `ring_mode`=1 and source byte equal to `node_id`, the packet is absorbed and appears on neither port.
- R4: On a forwarded packet every byte is unchanged except byte 3. That byte leaves as the incoming value plus one, and stays at 255 when it arrives as 255.
- R5: When `hop_limit` is nonzero and the incoming hop byte is greater than or equal to it, the packet is not forwarded and `drop_err` stays low. A broadcast caught by this rule is still delivered to the host. With `hop_limit`=0 the rule is off.
- R6: With `ring_mode`=0 and `line_end`=1, the node forwards nothing. A unicast packet that is not for this node is then dropped, with exactly one single-cycle pulse on `drop_err`. A broadcast goes only to the host, with no pulse. The R5 hop-limit rule takes precedence over this rule and raises no pulse.
- R7: A host packet leaves downstream with byte 1 replaced by `node_id` and byte 3 replaced by 0. Every other byte is unchanged.
- R8: Downstream packets never interleave, and once a packet starts it is sent to its last byte. A host packet that becomes valid while a forward is in progress goes out right after that forward. When both sources wait at a choice point, the source not served last goes first, and forward goes first after reset.
- R9: A forwarded packet's header and the payload received so far appear downstream while the rest of the packet has not yet arrived upstream.
- R10: While `dn_valid` or `hout_valid` is high and its ready is low, that output's data and last flag hold steady. Under stalls on both sinks, a broadcast still reaches each of them exactly once, byte-exact.
- R11: After reset `dn_valid`, `hout_valid` and `drop_err` are low and `up_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 8 | This node's address |
| ring_mode | input | 1 | 1 = ring topology, 0 = line |
| line_end | input | 1 | 1 = this node is the last on a line |
| hop_limit | input | 8 | Hop limit for forwarding, 0 = off |
| up_valid | input | 1 | Upstream byte valid |
| up_data | input | 8 | Upstream byte |
| up_last | input | 1 | Upstream last byte of packet |
| up_ready | output | 1 | Upstream byte accepted |
| hin_valid | input | 1 | Host transmit byte valid |
| hin_data | input | 8 | Host transmit byte |
| hin_last | input | 1 | Host transmit last byte |
| hin_ready | output | 1 | Host transmit byte accepted |
| dn_valid | output | 1 | Downstream byte valid |
| dn_data | output | 8 | Downstream byte |
| dn_last | output | 1 | Downstream last byte |
| dn_ready | input | 1 | Downstream sink ready |
| hout_valid | output | 1 | Host receive byte valid |
| hout_data | output | 8 | Host receive byte |
| hout_last | output | 1 | Host receive last byte |
| hout_ready | input | 1 | Host sink ready |
| drop_err | output | 1 | Pulse on an undeliverable unicast at line end |

## Verification
A header byte counter that slips is the most likely internal fault. If it does, the next packet routes on the wrong byte and appears on the wrong port, or has its hop count bumped at the wrong position. This shows up within the few cycles the packet takes to leave. A fork that loses track of which sink has already taken a byte duplicates or drops a broadcast byte under backpressure, and the first stalled byte shows it. An arbiter grant that releases early interleaves the two sources within one packet's length.

// File: rtl/rns_pkg.sv
package rns_pkg;
  localparam int BW      = 8;
  localparam int HDR_LEN = 4;
  localparam int IDX_SRC = 1;
  localparam int IDX_DST = 2;
  localparam int IDX_HOP = HDR_LEN - 1;
  localparam int IDX_W   = $clog2(HDR_LEN);
  localparam int POS_W   = $clog2(HDR_LEN + 1);

  localparam logic [BW-1:0] ID_BCAST = {BW{1'b1}};
  localparam logic [BW-1:0] ID_NEIGH = {{(BW-1){1'b1}}, 1'b0};

  typedef struct packed {
    logic to_host;
    logic to_fwd;
    logic err;
  } route_t;

  typedef enum logic [1:0] {ST_HDR, ST_REPLAY, ST_PASS, ST_DRAIN} ing_st_e;
  typedef enum logic [1:0] {G_IDLE, G_FWD, G_HOST} gnt_e;

  function automatic logic [BW-1:0] hop_bump(input logic [BW-1:0] h);
    return (h == {BW{1'b1}}) ? h : h + 1'b1;
  endfunction

  function automatic route_t route_decide(
    input logic [BW-1:0] dst,
    input logic [BW-1:0] src,
    input logic [BW-1:0] hop,
    input logic [BW-1:0] me,
    input logic          ring,
    input logic          at_end,
    input logic [BW-1:0] limit
  );
    route_t r;
    logic   bc;
    r  = '0;
    bc = (dst == ID_BCAST);
    if (dst == ID_NEIGH || dst == me) begin
      r.to_host = 1'b1;
    end else if (bc && ring && src == me) begin
      r = '0;
    end else begin
      r.to_host = bc;
      if (limit != '0 && hop >= limit) r.to_fwd = 1'b0;
      else if (!ring && at_end)        r.err    = !bc;
      else                             r.to_fwd = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [BW-1:0] host_rewrite(
    input logic [POS_W-1:0] pos,
    input logic [BW-1:0]    b,
    input logic [BW-1:0]    me
  );
    if (pos == POS_W'(IDX_SRC)) return me;
    if (pos == POS_W'(IDX_HOP)) return '0;
    return b;
  endfunction
endpackage

// File: rtl/rns_ingress.sv
module rns_ingress
  import rns_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] node_id,
  input  logic          ring_mode,
  input  logic          line_end,
  input  logic [BW-1:0] hop_limit,
  input  logic          up_valid,
  input  logic [BW-1:0] up_data,
  input  logic          up_last,
  output logic          up_ready,
  output logic          f_valid,
  output logic [BW-1:0] f_data,
  output logic          f_last,
  input  logic          f_ready,
  output logic          h_valid,
  output logic [BW-1:0] h_data,
  output logic          h_last,
  input  logic          h_ready,
  output logic          dec_fire,
  output logic [BW-1:0] dec_src,
  output logic [BW-1:0] dec_dst,
  output logic          dec_fwd,
  output logic          dec_host,
  output logic          drop_err
);
  ing_st_e        st;
  logic [BW-1:0]  hdr_q [HDR_LEN];
  logic [IDX_W-1:0] cnt, idx;
  logic           hdr_last, en_fwd, en_host, err_q;
  logic [1:0]     taken;
  logic           have, active, adv, blast;
  logic [BW-1:0]  byte_h, byte_f;
  route_t         rt;

  assign rt       = route_decide(hdr_q[IDX_DST], hdr_q[IDX_SRC], up_data,
                                 node_id, ring_mode, line_end, hop_limit);
  assign dec_fire = (st == ST_HDR) && up_valid && (cnt == IDX_W'(HDR_LEN-1));
  assign dec_src  = hdr_q[IDX_SRC];
  assign dec_dst  = hdr_q[IDX_DST];
  assign dec_fwd  = rt.to_fwd;
  assign dec_host = rt.to_host;
  assign drop_err = err_q;

  always_comb begin
    have   = 1'b0;
    byte_h = up_data;
    byte_f = up_data;
    blast  = up_last;
    if (st == ST_REPLAY) begin
      have   = 1'b1;
      byte_h = hdr_q[idx];
      byte_f = (idx == IDX_W'(IDX_HOP)) ? hop_bump(hdr_q[idx]) : hdr_q[idx];
      blast  = (idx == IDX_W'(IDX_HOP)) && hdr_last;
    end else if (st == ST_PASS) begin
      have = up_valid;
    end
  end

  assign active  = (st == ST_REPLAY) || (st == ST_PASS);
  assign f_valid = active && have && en_fwd  && !taken[0];
  assign h_valid = active && have && en_host && !taken[1];
  assign f_data  = byte_f;
  assign h_data  = byte_h;
  assign f_last  = blast;
  assign h_last  = blast;
  assign adv     = active && have &&
                   (!en_fwd  || taken[0] || f_ready) &&
                   (!en_host || taken[1] || h_ready);
  assign up_ready = (st == ST_HDR) || (st == ST_DRAIN) || ((st == ST_PASS) && adv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_HDR;
      cnt      <= '0;
      idx      <= '0;
      hdr_last <= 1'b0;
      en_fwd   <= 1'b0;
      en_host  <= 1'b0;
      taken    <= '0;
      err_q    <= 1'b0;
      for (int i = 0; i < HDR_LEN; i++) hdr_q[i] <= '0;
    end else begin
      err_q <= dec_fire && rt.err;
      case (st)
        ST_HDR: if (up_valid) begin
          hdr_q[cnt] <= up_data;
          if (cnt == IDX_W'(HDR_LEN-1)) begin
            cnt      <= '0;
            idx      <= '0;
            taken    <= '0;
            hdr_last <= up_last;
            en_fwd   <= rt.to_fwd;
            en_host  <= rt.to_host;
            if (rt.to_fwd || rt.to_host) st <= ST_REPLAY;
            else if (!up_last)           st <= ST_DRAIN;
          end else if (up_last) begin
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_REPLAY: begin
          if (adv) begin
            taken <= '0;
            if (idx == IDX_W'(HDR_LEN-1)) st <= hdr_last ? ST_HDR : ST_PASS;
            else                          idx <= idx + 1'b1;
          end else begin
            taken <= taken | {h_valid && h_ready, f_valid && f_ready};
          end
        end
        ST_PASS: begin
          if (adv) begin
            taken <= '0;
            if (up_last) st <= ST_HDR;
          end else begin
            taken <= taken | {h_valid && h_ready, f_valid && f_ready};
          end
        end
        default: if (up_valid && up_last) st <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/rns_hostfmt.sv
module rns_hostfmt
  import rns_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] node_id,
  input  logic          hin_valid,
  input  logic [BW-1:0] hin_data,
  input  logic          hin_last,
  output logic          hin_ready,
  output logic          o_valid,
  output logic [BW-1:0] o_data,
  output logic          o_last,
  input  logic          o_ready
);
  logic [POS_W-1:0] pos;

  assign o_valid   = hin_valid;
  assign o_last    = hin_last;
  assign o_data    = host_rewrite(pos, hin_data, node_id);
  assign hin_ready = o_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (hin_valid && o_ready) begin
      if (hin_last)                      pos <= '0;
      else if (pos != POS_W'(HDR_LEN))   pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/rns_arbiter.sv
module rns_arbiter
  import rns_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_valid,
  input  logic [BW-1:0] f_data,
  input  logic          f_last,
  output logic          f_ready,
  input  logic          h_valid,
  input  logic [BW-1:0] h_data,
  input  logic          h_last,
  output logic          h_ready,
  output logic          dn_valid,
  output logic [BW-1:0] dn_data,
  output logic          dn_last,
  input  logic          dn_ready,
  output logic          gnt_fwd,
  output logic          gnt_host
);
  gnt_e gnt;
  logic last_fwd;

  assign gnt_fwd  = (gnt == G_FWD);
  assign gnt_host = (gnt == G_HOST);
  assign f_ready  = gnt_fwd  && dn_ready;
  assign h_ready  = gnt_host && dn_ready;
  assign dn_valid = (gnt_fwd && f_valid) || (gnt_host && h_valid);
  assign dn_data  = gnt_host ? h_data : f_data;
  assign dn_last  = gnt_host ? h_last : (gnt_fwd && f_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt      <= G_IDLE;
      last_fwd <= 1'b0;
    end else begin
      case (gnt)
        G_IDLE: begin
          if (f_valid && h_valid) gnt <= last_fwd ? G_HOST : G_FWD;
          else if (f_valid)       gnt <= G_FWD;
          else if (h_valid)       gnt <= G_HOST;
        end
        G_FWD: if (f_valid && dn_ready && f_last) begin
          gnt      <= G_IDLE;
          last_fwd <= 1'b1;
        end
        default: if (h_valid && dn_ready && h_last) begin
          gnt      <= G_IDLE;
          last_fwd <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ring_node_switch.sv
module ring_node_switch
  import rns_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] node_id,
  input  logic          ring_mode,
  input  logic          line_end,
  input  logic [BW-1:0] hop_limit,
  input  logic          up_valid,
  input  logic [BW-1:0] up_data,
  input  logic          up_last,
  output logic          up_ready,
  input  logic          hin_valid,
  input  logic [BW-1:0] hin_data,
  input  logic          hin_last,
  output logic          hin_ready,
  output logic          dn_valid,
  output logic [BW-1:0] dn_data,
  output logic          dn_last,
  input  logic          dn_ready,
  output logic          hout_valid,
  output logic [BW-1:0] hout_data,
  output logic          hout_last,
  input  logic          hout_ready,
  output logic          drop_err
);
  logic          f_valid, f_last, f_ready;
  logic [BW-1:0] f_data;
  logic          hx_valid, hx_last, hx_ready;
  logic [BW-1:0] hx_data;
  logic          dec_fire, dec_fwd, dec_host;
  logic [BW-1:0] dec_src, dec_dst;
  logic          gnt_fwd, gnt_host;

  rns_ingress u_ing (
    .clk, .rst_n, .node_id, .ring_mode, .line_end, .hop_limit,
    .up_valid, .up_data, .up_last, .up_ready,
    .f_valid, .f_data, .f_last, .f_ready,
    .h_valid(hout_valid), .h_data(hout_data), .h_last(hout_last), .h_ready(hout_ready),
    .dec_fire, .dec_src, .dec_dst, .dec_fwd, .dec_host, .drop_err
  );

  rns_hostfmt u_hfmt (
    .clk, .rst_n, .node_id,
    .hin_valid, .hin_data, .hin_last, .hin_ready,
    .o_valid(hx_valid), .o_data(hx_data), .o_last(hx_last), .o_ready(hx_ready)
  );

  rns_arbiter u_arb (
    .clk, .rst_n,
    .f_valid, .f_data, .f_last, .f_ready,
    .h_valid(hx_valid), .h_data(hx_data), .h_last(hx_last), .h_ready(hx_ready),
    .dn_valid, .dn_data, .dn_last, .dn_ready,
    .gnt_fwd, .gnt_host
  );
endmodule

// File: rtl/rns_checker.sv
module rns_checker
  import rns_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [BW-1:0] node_id,
  input logic          ring_mode,
  input logic          line_end,
  input logic          dn_valid,
  input logic [BW-1:0] dn_data,
  input logic          dn_last,
  input logic          dn_ready,
  input logic          hout_valid,
  input logic [BW-1:0] hout_data,
  input logic          hout_last,
  input logic          hout_ready,
  input logic          drop_err,
  input logic          dec_fire,
  input logic [BW-1:0] dec_src,
  input logic [BW-1:0] dec_dst,
  input logic          dec_fwd,
  input logic          dec_host,
  input logic          gnt_fwd,
  input logic          gnt_host
);
  a_r10_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data) && $stable(dn_last));

  a_r10_hout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hout_valid && !hout_ready |=> hout_valid && $stable(hout_data) && $stable(hout_last));

  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |=> !drop_err);

  a_r6_err_line_only: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |-> $past(!ring_mode && line_end));

  a_r2_neigh_local: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire && dec_dst == ID_NEIGH |-> dec_host && !dec_fwd);

  a_r3_return_absorbed: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire && ring_mode && dec_dst == ID_BCAST && dec_src == node_id |-> !dec_host && !dec_fwd);

  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_fwd, gnt_host}));

  a_r8_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_fwd && !(dn_valid && dn_ready && dn_last) |=> gnt_fwd);

  a_r8_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_host && !(dn_valid && dn_ready && dn_last) |=> gnt_host);
endmodule

bind ring_node_switch rns_checker i_rns_checker (
  .clk(clk), .rst_n(rst_n), .node_id(node_id), .ring_mode(ring_mode), .line_end(line_end),
  .dn_valid(dn_valid), .dn_data(dn_data), .dn_last(dn_last), .dn_ready(dn_ready),
  .hout_valid(hout_valid), .hout_data(hout_data), .hout_last(hout_last), .hout_ready(hout_ready),
  .drop_err(drop_err), .dec_fire(dec_fire), .dec_src(dec_src), .dec_dst(dec_dst),
  .dec_fwd(dec_fwd), .dec_host(dec_host), .gnt_fwd(gnt_fwd), .gnt_host(gnt_host)
);

// File: tb/test_ring_node_switch.sv
`timescale 1ns/1ps
module test_ring_node_switch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_id = 8'd3, cfg_lim = 8'd0;
  logic cfg_ring = 1'b0, cfg_end = 1'b0;
  logic up_valid = 1'b0, up_last = 1'b0, hin_valid = 1'b0, hin_last = 1'b0;
  logic [7:0] up_data = '0, hin_data = '0;
  logic up_ready, hin_ready, dn_valid, dn_last, hout_valid, hout_last, drop_err;
  logic [7:0] dn_data, hout_data;
  logic dn_ready = 1'b1, hout_ready = 1'b1;
  logic stall = 1'b0;
  logic [1:0] sc = '0;

  int n_tests = 0, n_fail = 0;
  int dn_cnt = 0, h_cnt = 0, err_cnt = 0;
  logic [8:0] dn_log [1024];
  logic [8:0] h_log  [1024];
  logic [7:0] up_pkt [64];
  logic [7:0] host_pkt [64];
  logic [8:0] exp_dn [64];
  logic [8:0] exp_h  [64];
  int up_n = 0, host_n = 0, exp_dn_n = 0, exp_h_n = 0;

  always #2.5 clk = ~clk;

  ring_node_switch i_ring_node_switch (
    .clk, .rst_n, .node_id(cfg_id), .ring_mode(cfg_ring), .line_end(cfg_end), .hop_limit(cfg_lim),
    .up_valid, .up_data, .up_last, .up_ready,
    .hin_valid, .hin_data, .hin_last, .hin_ready,
    .dn_valid, .dn_data, .dn_last, .dn_ready,
    .hout_valid, .hout_data, .hout_last, .hout_ready, .drop_err
  );

  always @(negedge clk) begin
    sc = sc + 2'd1;
    dn_ready   = !stall || sc[0];
    hout_ready = !stall || (sc == 2'd2);
  end

  always @(posedge clk) begin
    if (rst_n && dn_valid && dn_ready) begin
      dn_log[dn_cnt] <= {dn_last, dn_data};
      dn_cnt <= dn_cnt + 1;
    end
    if (rst_n && hout_valid && hout_ready) begin
      h_log[h_cnt] <= {hout_last, hout_data};
      h_cnt <= h_cnt + 1;
    end
    if (rst_n && drop_err) err_cnt <= err_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mk(input logic [7:0] f, s, d, hp, input int plen);
    up_pkt[0] = f; up_pkt[1] = s; up_pkt[2] = d; up_pkt[3] = hp;
    for (int i = 0; i < plen; i++) up_pkt[4+i] = 8'(8'h40 + i * 7 + d);
    up_n = 4 + plen;
  endtask

  // bench routing model: returns {fwd, host, err}
  function automatic logic [2:0] ref_route(input logic [7:0] d, s, hp);
    logic mine, back, limited, at_end, fwd_ok;
    mine    = (d == 8'd254) || (d == cfg_id);
    back    = (d == 8'd255) && cfg_ring && (s == cfg_id);
    limited = (cfg_lim != 0) && (hp >= cfg_lim);
    at_end  = !cfg_ring && cfg_end;
    fwd_ok  = !mine && !back;
    return {fwd_ok && !limited && !at_end,
            mine || ((d == 8'd255) && !back),
            fwd_ok && !limited && at_end && (d != 8'd255)};
  endfunction

  task automatic build_exp();
    logic [2:0] r;
    exp_dn_n = 0; exp_h_n = 0;
    if (up_n >= 4) begin
      r = ref_route(up_pkt[2], up_pkt[1], up_pkt[3]);
      for (int i = 0; i < up_n; i++) begin
        if (r[2]) begin
          exp_dn[i] = {i == up_n - 1, (i == 3) ? ((up_pkt[3] == 8'hFF) ? 8'hFF : up_pkt[3] + 8'd1) : up_pkt[i]};
          exp_dn_n++;
        end
        if (r[1]) begin
          exp_h[i] = {i == up_n - 1, up_pkt[i]};
          exp_h_n++;
        end
      end
    end
  endtask

  task automatic send_up(input int n, input int gap_at, input int gap);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (i == gap_at) begin
        up_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
      up_valid = 1'b1; up_data = up_pkt[i]; up_last = (i == n - 1);
      #1;
      while (!up_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    up_valid = 1'b0; up_last = 1'b0;
  endtask

  task automatic send_host(input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      hin_valid = 1'b1; hin_data = host_pkt[i]; hin_last = (i == n - 1);
      #1;
      while (!hin_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    hin_valid = 1'b0; hin_last = 1'b0;
  endtask

  task automatic check_seg(input bit is_dn, input int base, input string tag);
    int got, expn, bad;
    logic [8:0] a, e;
    got  = (is_dn ? dn_cnt : h_cnt) - base;
    expn = is_dn ? exp_dn_n : exp_h_n;
    chk(got == expn, {tag, is_dn ? " dn count" : " host count"}, got, expn);
    if (got == expn) begin
      bad = -1; a = '0; e = '0;
      for (int i = 0; i < expn; i++) begin
        if (bad < 0) begin
          a = is_dn ? dn_log[base+i] : h_log[base+i];
          e = is_dn ? exp_dn[i] : exp_h[i];
          if (a !== e) bad = i;
        end
      end
      chk(bad < 0, {tag, is_dn ? " dn bytes" : " host bytes"}, int'(a), int'(e));
    end
  endtask

  task automatic run_up(input string tag, input int wait_cyc);
    int bd, bh, be;
    logic [2:0] r;
    bd = dn_cnt; bh = h_cnt; be = err_cnt;
    build_exp();
    r = (up_n >= 4) ? ref_route(up_pkt[2], up_pkt[1], up_pkt[3]) : 3'b000;
    send_up(up_n, -1, 0);
    repeat (wait_cyc) @(negedge clk);
    check_seg(1'b1, bd, tag);
    check_seg(1'b0, bh, tag);
    chk(err_cnt - be == int'(r[0]), {tag, " drop_err pulses"}, err_cnt - be, int'(r[0]));
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(!dn_valid,   "R11 dn_valid after reset", int'(dn_valid), 0);
    chk(!hout_valid, "R11 hout_valid after reset", int'(hout_valid), 0);
    chk(!drop_err,   "R11 drop_err after reset", int'(drop_err), 0);
    chk(up_ready,    "R11 up_ready after reset", int'(up_ready), 1);
  endtask

  task automatic t_forward();
    mk(8'd1, 8'd9, 8'd7, 8'd5, 6);     run_up("R4 unicast forward", 40);
    mk(8'd2, 8'd9, 8'd7, 8'd255, 3);   run_up("R4 hop saturate", 40);
  endtask

  task automatic t_local();
    mk(8'd1, 8'd9, 8'd3, 8'd2, 5);     run_up("R2 own id", 40);
    mk(8'd1, 8'd9, 8'd254, 8'd0, 1);   run_up("R2 neighbour", 40);
  endtask

  task automatic t_bcast();
    mk(8'd4, 8'd9, 8'd255, 8'd1, 4);   run_up("R3 broadcast line", 40);
    cfg_ring = 1'b1;
    mk(8'd4, 8'd3, 8'd255, 8'd6, 4);   run_up("R3 ring return", 40);
    mk(8'd4, 8'd8, 8'd255, 8'd6, 4);   run_up("R3 ring broadcast", 40);
    cfg_ring = 1'b0;
  endtask

  task automatic t_hoplimit();
    cfg_lim = 8'd4;
    mk(8'd1, 8'd9, 8'd7, 8'd4, 3);     run_up("R5 at limit", 40);
    mk(8'd1, 8'd9, 8'd7, 8'd3, 3);     run_up("R5 below limit", 40);
    mk(8'd1, 8'd9, 8'd255, 8'd6, 3);   run_up("R5 broadcast limited", 40);
    cfg_lim = 8'd0;
  endtask

  task automatic t_line_end();
    cfg_end = 1'b1;
    mk(8'd1, 8'd9, 8'd7, 8'd1, 3);     run_up("R6 unicast at end", 40);
    mk(8'd1, 8'd9, 8'd255, 8'd1, 3);   run_up("R6 broadcast at end", 40);
    cfg_lim = 8'd2;
    mk(8'd1, 8'd9, 8'd7, 8'd5, 3);     run_up("R6 hop limit first", 40);
    cfg_lim = 8'd0; cfg_end = 1'b0;
  endtask

  task automatic t_short();
    int bd, bh;
    bd = dn_cnt; bh = h_cnt;
    mk(8'd1, 8'd9, 8'd7, 8'd1, 0);
    send_up(2, -1, 0);
    repeat (10) @(negedge clk);
    chk(dn_cnt == bd && h_cnt == bh, "R1 short packet discarded", dn_cnt - bd + h_cnt - bh, 0);
    mk(8'd5, 8'd9, 8'd7, 8'd2, 0);     run_up("R1 header-only packet", 40);
    mk(8'd5, 8'd9, 8'd7, 8'd2, 2);     run_up("R1 packet after short", 40);
  endtask

  task automatic t_host();
    int bd, bh;
    bd = dn_cnt; bh = h_cnt;
    host_pkt[0] = 8'd9; host_pkt[1] = 8'd77; host_pkt[2] = 8'd5; host_pkt[3] = 8'd33;
    for (int i = 4; i < 8; i++) host_pkt[i] = 8'(8'h90 + i);
    host_n = 8;
    for (int i = 0; i < host_n; i++)
      exp_dn[i] = {i == host_n - 1, (i == 1) ? cfg_id : (i == 3) ? 8'd0 : host_pkt[i]};
    exp_dn_n = host_n; exp_h_n = 0;
    send_host(host_n);
    repeat (20) @(negedge clk);
    check_seg(1'b1, bd, "R7 host inject");
    check_seg(1'b0, bh, "R7 host inject");
  endtask

  task automatic t_cut();
    int bd, mid;
    bd = dn_cnt;
    mk(8'd1, 8'd9, 8'd7, 8'd0, 4);
    build_exp();
    fork
      send_up(up_n, 5, 30);
    join_none
    repeat (25) @(negedge clk);
    mid = dn_cnt - bd;
    chk(mid >= 4 && mid < up_n, "R9 cut-through before packet end", mid, 5);
    wait fork;
    repeat (30) @(negedge clk);
    check_seg(1'b1, bd, "R9 cut-through");
  endtask

  task automatic t_arb();
    int bd;
    bd = dn_cnt;
    mk(8'd1, 8'd9, 8'd7, 8'd0, 6);
    build_exp();
    host_pkt[0] = 8'd2; host_pkt[1] = 8'd0; host_pkt[2] = 8'd11; host_pkt[3] = 8'd9;
    host_pkt[4] = 8'hA5; host_n = 5;
    for (int i = 0; i < host_n; i++)
      exp_dn[exp_dn_n + i] = {i == host_n - 1, (i == 1) ? cfg_id : (i == 3) ? 8'd0 : host_pkt[i]};
    exp_dn_n = exp_dn_n + host_n;
    exp_h_n = 0;
    fork
      send_up(up_n, 6, 20);
      begin repeat (12) @(negedge clk); send_host(host_n); end
    join
    repeat (30) @(negedge clk);
    check_seg(1'b1, bd, "R8 forward then waiting host");
  endtask

  task automatic t_backpressure();
    stall = 1'b1;
    mk(8'd6, 8'd9, 8'd255, 8'd2, 12);  run_up("R10 broadcast under stall", 200);
    stall = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_forward();
    t_local();
    t_bcast();
    t_hoplimit();
    t_line_end();
    t_short();
    t_host();
    t_cut();
    t_arb();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule